// File: doc/BRIEF.md
# Dual-Input Non-Retriggerable One-Shot

This block is a clocked monostable pulse generator. It has two trigger inputs: one fires on its falling edge, the other on its rising edge, and each is qualified by the level of the other. An accepted trigger drives a single output pulse whose length, in clock cycles, is taken from a width input at the moment of acceptance. While a pulse runs, further trigger edges are ignored. A complementary output is always available.

An active-low clear input ends any pulse at once and blocks triggering while held low. If, during a clear, the inputs first leave the idle level (fall-trigger high or rise-trigger low) and then return to it (fall-trigger low, rise-trigger high), the rising edge of the clear fires a pulse. The trigger inputs and the clear pass through two-flop synchronizers, so the block accepts asynchronous sources. A separate system reset puts the block in its cleared, idle state at power-up.

Top module: `dual_oneshot`

## Requirements
- R1: A falling edge on fall_trig_i while rise_trig_i is high starts a pulse. pulse_o rises on the third rising clock edge after the input change and stays high for width_i cycles. A rising edge on fall_trig_i never starts a pulse, and neither does a falling edge while rise_trig_i is low.
- R2: A rising edge on rise_trig_i while fall_trig_i is low starts a pulse with the same timing as R1. A falling edge on rise_trig_i never starts a pulse, and neither does a rising edge while fall_trig_i is high.
- R3: While a pulse runs, trigger edges on either input do not restart or extend it.
- R4: While clr_ni is low, pulse_o is 0 in the same cycle, any running pulse ends, and no trigger edge is accepted. clr_ni must be held low for at least 3 clock cycles.
- R5: A pulse starts when clr_ni rises, with the R1 timing counted from that edge, if all of these hold: while clr_ni was low, the inputs were first not idle (fall_trig_i high or rise_trig_i low) and then idle (fall_trig_i low and rise_trig_i high), and they are still idle at the release. Without that prior non-idle state, releasing the clear starts no pulse.
- R6: While rst_ni is low and after its release with no trigger, pulse_o is 0 and pulse_no is 1.
- R7: pulse_no is always the inverse of pulse_o.
- R8: width_i is captured when a trigger is accepted. Changing it during a pulse has no effect, and a captured width of 0 produces no pulse. Widths of 1 and 2^CNT_W-1 are supported.
- R9: A trigger edge detected in the last cycle of a pulse is ignored. An edge detected one cycle later starts a new pulse, leaving one low cycle between the two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| fall_trig_i | input | 1 | Trigger on falling edge, qualified by rise_trig_i high |
| rise_trig_i | input | 1 | Trigger on rising edge, qualified by fall_trig_i low |
| clr_ni | input | 1 | Active-low clear; its release can fire a pulse |
| width_i | input | CNT_W | Pulse length in clock cycles |
| pulse_o | output | 1 | True pulse output, active high |
| pulse_no | output | 1 | Complement of pulse_o |

## Verification
Two functions can land in the same cycle: the end of a running pulse and the detection of a new trigger edge. The bench provokes this with a rise-trigger edge timed so that it is detected in the last pulse cycle, and expects exactly one pulse of the programmed length. It then repeats the sequence with the edge one cycle later and expects a second pulse after a single low cycle. In the clear test, armed, non-armed and broken release sequences meet the clear's rising edge, and the bench judges whether a pulse follows by counting high samples over a fixed window.

// File: rtl/dual_oneshot_pkg.sv
package dual_oneshot_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic clr;
    logic rise_trig;
    logic fall_trig;
  } trig_bus_t;

  localparam int unsigned TRIG_BUS_W = $bits(trig_bus_t);
endpackage

// File: rtl/dual_oneshot_sync.sv
module dual_oneshot_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dual_oneshot_trigger.sv
module dual_oneshot_trigger
  import dual_oneshot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trig_bus_t sync_i,
  output logic      fire_o
);
  trig_bus_t prev_q;
  logic      prior_q, arm_q;
  logic      fall_a, rise_b, rise_clr, idle_lvl;

  assign fall_a   = prev_q.fall_trig & ~sync_i.fall_trig;
  assign rise_b   = ~prev_q.rise_trig & sync_i.rise_trig;
  assign rise_clr = ~prev_q.clr & sync_i.clr;
  assign idle_lvl = ~sync_i.fall_trig & sync_i.rise_trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prior_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (sync_i.clr) begin
        prior_q <= 1'b0;
        arm_q   <= 1'b0;
      end else if (!idle_lvl) begin
        // non-idle level during clear: remember it, drop any arming
        prior_q <= 1'b1;
        arm_q   <= 1'b0;
      end else begin
        arm_q <= prior_q;
      end
    end
  end

  assign fire_o = (sync_i.clr & ((fall_a & sync_i.rise_trig) | (rise_b & ~sync_i.fall_trig)))
                | (rise_clr & arm_q & idle_lvl);

  assert_arm_in_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arm_q) |-> $past(!sync_i.clr));
endmodule

// File: rtl/dual_oneshot_timer.sv
module dual_oneshot_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_s_i,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!clr_s_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      // non-retriggerable: edges are not looked at while running
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - LAST;
      end
    end else if (fire_i && width_i != '0) begin
      run_q <= 1'b1;
      cnt_q <= width_i;
    end
  end

  assign run_o = run_q;

  assert_no_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && $past(clr_s_i)) |-> (cnt_q == $past(cnt_q) - LAST));

  assert_expiry_ignores_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && $past(cnt_q) == LAST) |-> !run_q);

  assert_clear_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s_i |=> !run_q);
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot
  import dual_oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_trig_i,
  input  logic             rise_trig_i,
  input  logic             clr_ni,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_no
);
  trig_bus_t raw_bus, sync_bus;
  logic      fire, run;

  assign raw_bus = '{clr: clr_ni, rise_trig: rise_trig_i, fall_trig: fall_trig_i};

  dual_oneshot_sync #(
    .WIDTH  (TRIG_BUS_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_bus),
    .q_o    (sync_bus)
  );

  dual_oneshot_trigger u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_bus),
    .fire_o (fire)
  );

  dual_oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_s_i (sync_bus.clr),
    .fire_i  (fire),
    .width_i (width_i),
    .run_o   (run)
  );

  // raw clear gates the output so it drops before the synchronizer catches up
  assign pulse_o  = run & clr_ni;
  assign pulse_no = ~pulse_o;

  assert_zero_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> ($past(width_i) != '0));
endmodule

// File: tb/dual_oneshot_test.sv
module dual_oneshot_test;
  localparam int unsigned CNT_W = 8;
  localparam int NVEC = 9;
  // {a0, b0, a1, b1, width[7:0], expected high cycles[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b1101, 8'd5,   8'd5},
    {4'b1000, 8'd5,   8'd0},
    {4'b0001, 8'd7,   8'd7},
    {4'b1011, 8'd7,   8'd0},
    {4'b0111, 8'd5,   8'd0},
    {4'b0100, 8'd5,   8'd0},
    {4'b1101, 8'd1,   8'd1},
    {4'b0001, 8'd0,   8'd0},
    {4'b0001, 8'd255, 8'd255}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fall_trig_i = 1'b0, rise_trig_i = 1'b0, clr_ni = 1'b1;
  logic [CNT_W-1:0] width_i = '0;
  logic pulse_o, pulse_no;

  int checks = 0, failures = 0, cyc = 0;
  int hi_cnt, starts, first_hi, comp_bad;
  logic prev_p;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_oneshot #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fall_trig_i(fall_trig_i), .rise_trig_i(rise_trig_i),
    .clr_ni(clr_ni), .width_i(width_i), .pulse_o(pulse_o), .pulse_no(pulse_no)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; failures++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      finish_run();
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_rec();
    hi_cnt = 0; starts = 0; first_hi = -1; comp_bad = 0; prev_p = 1'b0;
  endtask

  task automatic rec(int i);
    if (pulse_o && !prev_p) begin
      starts++;
      if (first_hi < 0) first_hi = i;
    end
    if (pulse_o) hi_cnt++;
    if (pulse_no !== ~pulse_o) comp_bad++;
    prev_p = pulse_o;
  endtask

  initial begin
    // R6: power-up state
    settle(3);
    check(pulse_o == 1'b0 && pulse_no == 1'b1, "R6 in reset", pulse_o, 0);
    rst_ni = 1'b1;
    settle(6);
    check(pulse_o == 1'b0 && pulse_no == 1'b1, "R6 after release", pulse_o, 0);

    // R1 R2 R8: vector table
    for (int v = 0; v < NVEC; v++) begin
      fall_trig_i = VEC[v][19];
      rise_trig_i = VEC[v][18];
      width_i     = VEC[v][15:8];
      settle(300);
      clear_rec();
      for (int i = 0; i < 280; i++) begin
        @(negedge clk);
        if (i == 0) begin
          fall_trig_i = VEC[v][17];
          rise_trig_i = VEC[v][16];
        end
        #1 rec(i);
      end
      check(hi_cnt == int'(VEC[v][7:0]), $sformatf("R1/R2/R8 vector %0d length", v),
            hi_cnt, int'(VEC[v][7:0]));
      if (VEC[v][7:0] != 0)
        check(first_hi == 3, $sformatf("R1/R2 vector %0d start", v), first_hi, 3);
      check(comp_bad == 0, $sformatf("R7 vector %0d complement", v), comp_bad, 0);
    end

    // R3 and R8: edges and width change during a pulse
    fall_trig_i = 1'b1; rise_trig_i = 1'b1; width_i = 8'd10;
    settle(20);
    clear_rec();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) fall_trig_i = 1'b0;
      if (i == 4) fall_trig_i = 1'b1;
      if (i == 5) width_i = 8'd2;
      if (i == 6) fall_trig_i = 1'b0;
      #1 rec(i);
    end
    check(hi_cnt == 10, "R3/R8 length unchanged", hi_cnt, 10);
    check(starts == 1, "R3 single pulse", starts, 1);

    // R9: edge detected in last pulse cycle is ignored
    fall_trig_i = 1'b0; rise_trig_i = 1'b0; width_i = 8'd4;
    settle(20);
    clear_rec();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 0) rise_trig_i = 1'b1;
      if (i == 2) rise_trig_i = 1'b0;
      if (i == 4) rise_trig_i = 1'b1;
      #1 rec(i);
    end
    check(hi_cnt == 4 && starts == 1, "R9 edge at expiry ignored", hi_cnt, 4);

    // R9: edge one cycle later is accepted after a single low cycle
    rise_trig_i = 1'b0;
    settle(20);
    clear_rec();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 0) rise_trig_i = 1'b1;
      if (i == 2) rise_trig_i = 1'b0;
      if (i == 5) rise_trig_i = 1'b1;
      #1 rec(i);
    end
    check(hi_cnt == 8, "R9 later edge accepted length", hi_cnt, 8);
    check(starts == 2, "R9 later edge second pulse", starts, 2);

    // R4: clear cuts pulse, blocks edges; broken arming gives no release pulse (R5)
    fall_trig_i = 1'b1; rise_trig_i = 1'b1; width_i = 8'd20;
    settle(30);
    clear_rec();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0)  fall_trig_i = 1'b0;
      if (i == 6)  clr_ni = 1'b0;
      if (i == 8)  fall_trig_i = 1'b1;
      if (i == 10) fall_trig_i = 1'b0;
      if (i == 13) fall_trig_i = 1'b1;
      if (i == 16) clr_ni = 1'b1;
      #1 rec(i);
      if (i == 6)
        check(pulse_o == 1'b0 && pulse_no == 1'b1, "R4 immediate clear", pulse_o, 0);
    end
    check(hi_cnt == 3 && starts == 1, "R4 pulse ended, no trigger in clear", hi_cnt, 3);

    // R5: armed release fires a pulse
    fall_trig_i = 1'b0; rise_trig_i = 1'b1; width_i = 8'd6;
    settle(30);
    clear_rec();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0)  clr_ni = 1'b0;
      if (i == 4)  fall_trig_i = 1'b1;
      if (i == 8)  fall_trig_i = 1'b0;
      if (i == 12) clr_ni = 1'b1;
      #1 rec(i);
    end
    check(hi_cnt == 6, "R5 release pulse length", hi_cnt, 6);
    check(first_hi == 15, "R5 release pulse start", first_hi, 15);
    check(comp_bad == 0, "R7 complement in release test", comp_bad, 0);

    // R5: no prior non-idle state, release does nothing
    settle(20);
    clear_rec();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0)  clr_ni = 1'b0;
      if (i == 12) clr_ni = 1'b1;
      #1 rec(i);
    end
    check(hi_cnt == 0, "R5 unarmed release no pulse", hi_cnt, 0);

    finish_run();
  end
endmodule